// File: doc/BRIEF.md
# Byte-Serial Command Deserializer

This block takes commands arriving one byte per clock on an 8-bit bus and turns each complete frame into a single wide register write. A frame holds six bytes: a 16-bit address and then a 32-bit data word. A strobe input goes high only together with the first byte, which marks where the frame starts. The block counts the bytes that follow and packs them into a frame register.

When the sixth byte arrives, the block compares the received address with a match value. Only the bits selected by a mask take part in the comparison. If the address matches, the block presents the 32-bit word and the low address bits on its outputs and raises a write-enable for one cycle. Logic further down uses these to select one of a small group of target registers. A strobe that arrives before a frame is complete abandons that frame and starts a new one. Bytes that arrive when no frame is open are dropped.

Top module: `cmd_rx`

## Requirements
- R1: A frame is sent in this order: address low byte (the byte that carries the strobe), address high byte, then data bytes D0, D1, D2 and D3. `data_o` equals {D3, D2, D1, D0}, so D0 is the least significant byte.
- R2: `we_o` is high for exactly one cycle. That cycle comes right after the clock edge that samples D3.
- R3: A frame is accepted only if `(addr & ADDR_MASK) == (MATCH_ADDR & ADDR_MASK)`. A frame that fails this test gives no `we_o` and leaves `data_o` and `addr_o` unchanged.
- R4: Address bits that are 0 in `ADDR_MASK` have no effect on acceptance. With mask 0x07FE, for example, addresses 0x0714 and 0xF714 are both accepted.
- R5: `addr_o` carries the low `ADDR_WIDTH` bits of the received address of the accepted frame.
- R6: A strobe during an open frame abandons that frame. The byte that carries the strobe becomes the address low byte of a new frame, and the abandoned frame never raises `we_o`.
- R7: Bytes without a strobe that arrive after a frame has completed, or while no frame is open, are ignored.
- R8: `data_o` and `addr_o` keep their values until the next accepted frame.
- R9: A high `srst_i` closes any open frame and clears `we_o`. Bytes of the rest of that frame that arrive without a strobe are ignored.
- R10: A low `rst_ni` clears `we_o`, `data_o`, `addr_o` and the collection state, without waiting for a clock edge.
- R11: A strobe in the cycle right after D3 starts a new frame. Two frames sent back to back each give their own write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous reset of the frame state |
| byte_i | input | 8 | Command byte for the current cycle |
| stb_i | input | 1 | Marks the first byte of a frame |
| addr_o | output | ADDR_WIDTH | Low address bits of the last accepted frame |
| data_o | output | 32 | Data word of the last accepted frame |
| we_o | output | 1 | One-cycle write pulse for an accepted frame |

## Verification
The byte stream is built from several kinds of frame:
- exact matches;
- addresses that differ from the match value only in masked-out bits, which separates masked from unmasked comparison;
- addresses that differ in a compared bit, which must give no write and must leave the outputs unchanged;
- addresses that differ only in the address bit brought out on `addr_o`, which shows that this bit is passed through.

Restarts are tested by breaking a frame at several byte positions, including the last one. Loose bytes are sent after a completed frame and after a synchronous reset. Together these show whether the byte counter starts again from the strobe or runs on through stale bytes. Frames sent back to back show whether a strobe in the cycle after D3 is lost. A scoreboard compares every write against its expected data, its `addr_o` value and the exact cycle in which it should appear.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/cmd_rx_seq.sv
module cmd_rx_seq #(
  parameter int unsigned NUM_BYTES = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 srst_i,
  input  logic                 stb_i,
  output logic [NUM_BYTES-1:0] lane_o,
  output logic                 last_o
);
  localparam int unsigned IDX_W = $clog2(NUM_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);
  localparam logic [IDX_W-1:0] NEXT_IDX = IDX_W'(1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    lane_o = '0;
    last_o = 1'b0;
    if (stb_i) begin
      lane_o[0] = 1'b1;
    end else if (active_q) begin
      lane_o[idx_q] = 1'b1;
      last_o        = (idx_q == LAST_IDX);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (srst_i) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (stb_i) begin
      active_q <= 1'b1;
      idx_q    <= NEXT_IDX;
    end else if (active_q) begin
      if (idx_q == LAST_IDX) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + NEXT_IDX;
      end
    end
  end

  // a strobe always reopens the frame at the second byte
  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !srst_i) |=> (active_q && idx_q == NEXT_IDX));

  p_srst_close_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> !active_q);

  p_idx_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !stb_i) |-> (lane_o == '0 && !last_o));
endmodule

// File: rtl/cmd_rx_collect.sv
module cmd_rx_collect
  import cmd_rx_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  byte_t                       byte_i,
  input  logic [NUM_BYTES-1:0]        lane_i,
  output logic [NUM_BYTES*BYTE_W-1:0] frame_o
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    byte_t lane_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lane_q <= '0;
      else if (lane_i[g]) lane_q <= byte_i;
    end

    assign frame_o[g*BYTE_W +: BYTE_W] = lane_q;

    p_lane_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lane_i[g] |=> (frame_o[g*BYTE_W +: BYTE_W] == $past(byte_i)));
  end
endmodule

// File: rtl/cmd_rx_match.sv
module cmd_rx_match #(
  parameter int unsigned           ADDR_BITS  = 16,
  parameter logic [ADDR_BITS-1:0]  MATCH_ADDR = '0,
  parameter logic [ADDR_BITS-1:0]  ADDR_MASK  = '1
) (
  input  logic [ADDR_BITS-1:0] addr_i,
  output logic                 hit_o
);
  assign hit_o = ((addr_i ^ MATCH_ADDR) & ADDR_MASK) == '0;
endmodule

// File: rtl/cmd_rx.sv
module cmd_rx
  import cmd_rx_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 2,
  parameter int unsigned DATA_BYTES = 4,
  parameter int unsigned ADDR_WIDTH = 1,
  parameter logic [ADDR_BYTES*8-1:0] MATCH_ADDR = 16'h0714,
  parameter logic [ADDR_BYTES*8-1:0] ADDR_MASK  = 16'h07ff
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      srst_i,
  input  logic [7:0]                byte_i,
  input  logic                      stb_i,
  output logic [ADDR_WIDTH-1:0]     addr_o,
  output logic [DATA_BYTES*8-1:0]   data_o,
  output logic                      we_o
);
  localparam int unsigned NUM_BYTES = ADDR_BYTES + DATA_BYTES;
  localparam int unsigned ADDR_BITS = ADDR_BYTES * BYTE_W;
  localparam int unsigned DATA_BITS = DATA_BYTES * BYTE_W;
  localparam int unsigned FRAME_W   = NUM_BYTES * BYTE_W;

  logic [NUM_BYTES-1:0] lane;
  logic                 last;
  logic [FRAME_W-1:0]   frame_q;
  logic [FRAME_W-1:0]   frame_full;
  logic                 hit;

  cmd_rx_seq #(.NUM_BYTES(NUM_BYTES)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (srst_i),
    .stb_i  (stb_i),
    .lane_o (lane),
    .last_o (last)
  );

  cmd_rx_collect #(.NUM_BYTES(NUM_BYTES)) u_collect (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .byte_i  (byte_i),
    .lane_i  (lane),
    .frame_o (frame_q)
  );

  // last byte bypasses the collector so the write leaves one cycle after D3
  assign frame_full = {byte_i, frame_q[FRAME_W-BYTE_W-1:0]};

  cmd_rx_match #(
    .ADDR_BITS  (ADDR_BITS),
    .MATCH_ADDR (MATCH_ADDR),
    .ADDR_MASK  (ADDR_MASK)
  ) u_match (
    .addr_i (frame_q[ADDR_BITS-1:0]),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      data_o <= '0;
      addr_o <= '0;
    end else if (srst_i) begin
      we_o <= 1'b0;
    end else begin
      we_o <= last && hit;
      if (last && hit) begin
        data_o <= frame_full[ADDR_BITS +: DATA_BITS];
        addr_o <= frame_q[ADDR_WIDTH-1:0];
      end
    end
  end

  p_we_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);

  p_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && hit && !srst_i) |=> (we_o && data_o[DATA_BITS-1 -: BYTE_W] == $past(byte_i)));

  p_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && !hit) |=> !we_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_o |-> ($stable(data_o) && $stable(addr_o)));
endmodule

// File: tb/cmd_rx_bench.sv
module cmd_rx_bench;
  localparam int unsigned AW = 1;

  typedef struct {
    logic [31:0]   data;
    logic [AW-1:0] addr;
    int            cyc;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          srst = 1'b0;
  logic [7:0]    byte_in = 8'h00;
  logic          stb = 1'b0;
  logic [AW-1:0] addr_o;
  logic [31:0]   data_o;
  logic          we_o;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    prev_we = 1'b0;
  item_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmd_rx #(
    .ADDR_BYTES (2),
    .DATA_BYTES (4),
    .ADDR_WIDTH (AW),
    .MATCH_ADDR (16'h0714),
    .ADDR_MASK  (16'h07fe)
  ) u_cmd_rx (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .srst_i (srst),
    .byte_i (byte_in),
    .stb_i  (stb),
    .addr_o (addr_o),
    .data_o (data_o),
    .we_o   (we_o)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b, logic s);
    @(negedge clk);
    byte_in = b;
    stb     = s;
  endtask

  task automatic send_frame(logic [15:0] a, logic [31:0] d, bit accept);
    @(negedge clk);
    byte_in = a[7:0];
    stb     = 1'b1;
    if (accept) exp_q.push_back('{data: d, addr: a[AW-1:0], cyc: cyc + 6});
    put(a[15:8], 1'b0);
    for (int i = 0; i < 4; i++) put(d[i*8 +: 8], 1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) put(8'ha5, 1'b0);
  endtask

  // monitor: pop and compare each write as it appears
  always @(negedge clk) begin
    if (rst_n) begin
      if (we_o && prev_we) check(1'b0, "R2 pulse longer than one cycle", 32'd2, 32'd1);
      if (we_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3/R6/R7/R9 unexpected write", data_o, 32'h0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check(data_o == e.data, "R1 data assembly", data_o, e.data);
          check(addr_o == e.addr, "R5 addr_o", 32'(addr_o), 32'(e.addr));
          check(cyc == e.cyc, "R2 write cycle", cyc, e.cyc);
        end
      end
      prev_we = we_o;
    end else begin
      prev_we = 1'b0;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(we_o == 1'b0 && data_o == 32'h0 && addr_o == '0, "R10 reset state",
          data_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    send_frame(16'h0714, 32'h11223344, 1'b1);   // R1 R3 exact match
    idle(3);
    send_frame(16'h0715, 32'ha5a55a5a, 1'b1);   // R5 addr_o = 1
    idle(3);
    send_frame(16'hf714, 32'hcafebabe, 1'b1);   // R4 upper bits masked out
    idle(3);
    send_frame(16'h0716, 32'hdeadbeef, 1'b0);   // R3 compared bit differs
    send_frame(16'h0614, 32'h0badf00d, 1'b0);   // R3 high byte differs
    idle(4);
    check(data_o == 32'hcafebabe, "R3 rejected frame kept data_o", data_o, 32'hcafebabe);
    check(addr_o == 1'b0, "R3 rejected frame kept addr_o", 32'(addr_o), 32'h0);

    // R11 back to back
    send_frame(16'h0714, 32'h01020304, 1'b1);
    send_frame(16'h0715, 32'h05060708, 1'b1);
    send_frame(16'h0714, 32'h090a0b0c, 1'b1);
    idle(3);

    // R6 abort at the D3 position, strobe byte is the new address low byte
    put(8'h14, 1'b1); put(8'h07, 1'b0);
    put(8'hee, 1'b0); put(8'hee, 1'b0); put(8'hee, 1'b0);
    send_frame(16'h0715, 32'h13579bdf, 1'b1);
    // R6 abort after the address
    put(8'h14, 1'b1); put(8'h07, 1'b0);
    send_frame(16'h0714, 32'h2468ace0, 1'b1);
    idle(3);

    // R7 loose bytes after completion
    put(8'h14, 1'b0); put(8'h07, 1'b0);
    for (int i = 0; i < 10; i++) put(8'(i * 17), 1'b0);
    idle(2);
    check(data_o == 32'h2468ace0, "R7 loose bytes ignored", data_o, 32'h2468ace0);
    check(we_o == 1'b0, "R8 we_o low between frames", 32'(we_o), 32'h0);

    // R9 synchronous reset in mid frame
    put(8'h14, 1'b1); put(8'h07, 1'b0); put(8'h11, 1'b0);
    @(negedge clk); byte_in = 8'h22; srst = 1'b1;
    @(negedge clk); srst = 1'b0; byte_in = 8'h33;
    put(8'h44, 1'b0); put(8'h55, 1'b0); put(8'h66, 1'b0);
    idle(3);
    check(data_o == 32'h2468ace0, "R9 frame discarded by srst", data_o, 32'h2468ace0);
    send_frame(16'h0714, 32'h89abcdef, 1'b1);   // R9 recovery
    idle(3);
    check(data_o == 32'h89abcdef, "R8 data_o held after write", data_o, 32'h89abcdef);

    // R10 asynchronous reset clears outputs
    send_frame(16'h0715, 32'h76543210, 1'b1);
    idle(2);
    #3 rst_n = 1'b0;
    #2 check(data_o == 32'h0 && addr_o == '0 && we_o == 1'b0, "R10 async clear",
             data_o, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    idle(1);
    send_frame(16'h0714, 32'hfeedface, 1'b1);
    idle(6);

    check(exp_q.size() == 0, "R1 all expected writes seen", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule